// File: doc/BRIEF.md
# Reference Validation Timer with Override

This block turns the raw fault flag of a clock-period monitor into a validity flag that the rest of the clock path can trust. A reference that has been faulted is not trusted again at once. It has to stay fault-free for a programmed number of milliseconds first. A millisecond tick is made inside the block by a programmable divider of the system clock. Each reference input has its own timer, manual-validation latch and override logic, and these run independently of each other.

Each reference has a 16-bit timeout. When the timeout is zero the timer is switched off, and the reference can only be validated by a manual strobe. That manual validation stays latched until the next fault. Two override inputs are applied over the automatic decision: one forces the reference valid and one forces it invalid. Force-invalid wins when both are set.

Top module: `ref_valid_timer`

## Requirements
- R1: While reset is held, and on its release, every channel's internal validity is cleared and its millisecond count is zero. With no override set, `valid` reads 0.
- R2: The tick divider issues one tick every `div_cfg`+1 system clock cycles. The first tick comes on the (`div_cfg`+1)-th rising edge after reset is released. Timer counts advance only on edges that carry a tick.
- R3: With a nonzero timeout T, validity is set on the rising edge that carries the T-th tick sampled since the last edge on which `fault` was high. The count then stops.
- R4: A high `fault` sampled on an edge clears that channel's validity, its manual latch and its count on that edge. A fault during a count restarts the count from zero.
- R5: With timeout 0, ticks never validate. A `man_validate` pulse sampled while `fault` is low sets validity on that edge, and validity holds until the next fault.
- R6: `man_validate` has no effect when the timeout is nonzero, or when `fault` is high on the same edge.
- R7: `force_valid` high with `force_invalid` low drives `valid` to 1 combinationally, whatever the internal state.
- R8: `force_invalid` high drives `valid` to 0 combinationally. It takes priority over `force_valid`.
- R9: Channels are independent. Bit i of `fault`, `man_validate`, the overrides and `timeout[16*i +: 16]` affect only `valid[i]`.
- R10: The full timeout of 65535 ms is honoured without wrapping. Validity is set on the 65535th tick and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W (8) | Tick divider; tick period is div_cfg+1 cycles |
| fault | input | NREF (2) | Per-reference fault flag from the period monitor |
| timeout | input | NREF*TMR_W (32) | Per-reference timeout in ticks (ms); 0 turns the timer off |
| man_validate | input | NREF (2) | Per-reference manual validate strobe |
| force_valid | input | NREF (2) | Per-reference override: treat as valid |
| force_invalid | input | NREF (2) | Per-reference override: treat as invalid (wins) |
| valid | output | NREF (2) | Per-reference validity flag |

## Verification
The bench sweeps several divider settings against several small timeouts, and checks the exact edge on which validity rises. This exposes an off-by-one in the tick period, and a timer that counts clock cycles where it should count ticks. Single-cycle fault glitches are placed in the middle of a count, which catches a timer that pauses where it should restart. In disabled mode the bench sends manual strobes that coincide with a fault, and strobes while a timer is active, to catch a latch that accepts them. All four override combinations are applied on top of both valid and invalid states. A run at the 65535 ms timeout checks that a narrow or wrapping count does not validate early or never.

// File: rtl/refval_pkg.sv
package refval_pkg;

  // Tick fires once the divider count has reached the configured limit.
  function automatic logic tick_due(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // True when one more fault-free tick completes the programmed timeout.
  function automatic logic timeout_done(input logic [31:0] ticks_so_far,
                                        input logic [31:0] limit);
    return (ticks_so_far + 32'd1) >= limit;
  endfunction

  // Override resolution: force-invalid beats force-valid beats automatic.
  function automatic logic resolve(input logic f_inv, input logic f_val, input logic raw);
    if (f_inv) return 1'b0;
    if (f_val) return 1'b1;
    return raw;
  endfunction

endpackage

// File: rtl/refval_tick_gen.sv
module refval_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  import refval_pkg::*;

  logic [DIV_W-1:0] cnt_q;

  assign tick = tick_due(32'(cnt_q), 32'(div_cfg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refval_channel.sv
module refval_channel #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fault,
  input  logic [TMR_W-1:0] timeout,
  input  logic             man_validate,
  output logic             raw_ok
);
  import refval_pkg::*;

  logic [TMR_W-1:0] ms_cnt_q;
  logic             auto_ok_q;
  logic             man_ok_q;
  logic             timer_off;
  logic             count_en;
  logic             man_take;

  assign timer_off = (timeout == '0);
  assign count_en  = !fault && !timer_off && !auto_ok_q && tick;
  assign man_take  = !fault && timer_off && man_validate;
  assign raw_ok    = auto_ok_q | man_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt_q  <= '0;
      auto_ok_q <= 1'b0;
      man_ok_q  <= 1'b0;
    end else if (fault) begin
      ms_cnt_q  <= '0;
      auto_ok_q <= 1'b0;
      man_ok_q  <= 1'b0;
    end else begin
      if (man_take) man_ok_q <= 1'b1;
      if (count_en) begin
        ms_cnt_q <= ms_cnt_q + 1'b1;
        if (timeout_done(32'(ms_cnt_q), 32'(timeout))) auto_ok_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/refval_override.sv
module refval_override #(
  parameter int NREF = 2
) (
  input  logic [NREF-1:0] raw_ok,
  input  logic [NREF-1:0] force_valid,
  input  logic [NREF-1:0] force_invalid,
  output logic [NREF-1:0] valid
);
  import refval_pkg::*;

  always_comb begin
    for (int i = 0; i < NREF; i++)
      valid[i] = resolve(force_invalid[i], force_valid[i], raw_ok[i]);
  end
endmodule

// File: rtl/ref_valid_timer.sv
module ref_valid_timer #(
  parameter int NREF  = 2,
  parameter int TMR_W = 16,
  parameter int DIV_W = 8,
  localparam int TBUS_W = NREF * TMR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [NREF-1:0]   fault,
  input  logic [TBUS_W-1:0] timeout,
  input  logic [NREF-1:0]   man_validate,
  input  logic [NREF-1:0]   force_valid,
  input  logic [NREF-1:0]   force_invalid,
  output logic [NREF-1:0]   valid
);
  logic            ms_tick;
  logic [NREF-1:0] raw_ok;

  refval_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .tick(ms_tick)
  );

  for (genvar g = 0; g < NREF; g++) begin : g_ch
    refval_channel #(.TMR_W(TMR_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .fault(fault[g]),
      .timeout(timeout[g*TMR_W +: TMR_W]), .man_validate(man_validate[g]),
      .raw_ok(raw_ok[g])
    );
  end

  refval_override #(.NREF(NREF)) u_ovr (
    .raw_ok(raw_ok), .force_valid(force_valid),
    .force_invalid(force_invalid), .valid(valid)
  );
endmodule

// File: rtl/refval_chk.sv
module refval_chk #(
  parameter int NREF  = 2,
  parameter int TMR_W = 16,
  parameter int DIV_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [DIV_W-1:0]      div_cfg,
  input logic                  ms_tick,
  input logic [NREF-1:0]       fault,
  input logic [NREF*TMR_W-1:0] timeout,
  input logic [NREF-1:0]       man_validate,
  input logic [NREF-1:0]       force_valid,
  input logic [NREF-1:0]       force_invalid,
  input logic [NREF-1:0]       raw_ok,
  input logic [NREF-1:0]       valid
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && div_cfg != '0) |=> (!ms_tick || div_cfg == '0));

  for (genvar i = 0; i < NREF; i++) begin : g_c
    // R8
    force_inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_invalid[i] |-> !valid[i]);
    // R7
    force_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_valid[i] && !force_invalid[i]) |-> valid[i]);
    // R4
    fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault[i] |=> !raw_ok[i]);
    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout[i*TMR_W +: TMR_W] != '0 && !raw_ok[i] && !ms_tick) |=> !raw_ok[i]);
    // R5
    off_needs_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout[i*TMR_W +: TMR_W] == '0 && !man_validate[i] && !raw_ok[i]) |=> !raw_ok[i]);
    // R5
    manual_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout[i*TMR_W +: TMR_W] == '0 && man_validate[i] && !fault[i]) |=> raw_ok[i]);
    // R4
    hold_until_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_ok[i] && !fault[i]) |=> raw_ok[i]);
  end
endmodule

bind ref_valid_timer refval_chk #(.NREF(NREF), .TMR_W(TMR_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .ms_tick(ms_tick), .fault(fault),
  .timeout(timeout), .man_validate(man_validate), .force_valid(force_valid),
  .force_invalid(force_invalid), .raw_ok(raw_ok), .valid(valid)
);

// File: tb/tb_ref_valid_timer.sv
module tb_ref_valid_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_cfg = '0;
  logic [1:0]  fault = '0, man = '0, fv = '0, fi = '0;
  logic [31:0] timeout = '0;
  logic [1:0]  valid;

  int checks = 0, fails = 0;
  int edge_n = 0;
  int m_ticks [2];
  bit m_auto [2];
  bit m_man [2];
  string tag = "R1";

  always #5 clk = ~clk;

  ref_valid_timer dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .fault(fault), .timeout(timeout),
    .man_validate(man), .force_valid(fv), .force_invalid(fi), .valid(valid)
  );

  function automatic int tmo(input int r);
    return int'(timeout[r*16 +: 16]);
  endfunction

  function automatic bit exp_valid(input int r);
    if (fi[r]) return 1'b0;
    if (fv[r]) return 1'b1;
    return m_auto[r] | m_man[r];
  endfunction

  task automatic check_all();
    for (int r = 0; r < 2; r++) begin
      checks++;
      if (valid[r] !== exp_valid(r)) begin
        fails++;
        $display("FAIL %s ref%0d edge %0d: valid=%b expected=%b", tag, r, edge_n, valid[r], exp_valid(r));
      end
    end
  endtask

  // Advance one clock; bench-side model follows the requirements directly.
  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      bit tk;
      @(posedge clk);
      edge_n++;
      tk = (edge_n % (int'(div_cfg) + 1)) == 0;   // R2: tick every div_cfg+1 edges
      for (int r = 0; r < 2; r++) begin
        if (fault[r]) begin
          m_ticks[r] = 0; m_auto[r] = 0; m_man[r] = 0;
        end else begin
          if (tmo(r) == 0 && man[r]) m_man[r] = 1;
          if (tmo(r) != 0 && !m_auto[r] && tk) begin
            m_ticks[r]++;
            if (m_ticks[r] >= tmo(r)) m_auto[r] = 1;
          end
        end
      end
      #2;
      check_all();
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; fault = '0; man = '0; fv = '0; fi = '0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    for (int r = 0; r < 2; r++) begin m_ticks[r] = 0; m_auto[r] = 0; m_man[r] = 0; end
    edge_n = 0;
    tag = "R1";
    check_all();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(10 * 300000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    timeout = {16'd1, 16'd1};
    do_reset();
    cyc(2);

    // R3 / R2 / R4 / R9: divider x timeout sweep with mid-count glitches
    for (int d = 0; d < 4; d++) begin
      for (int t = 1; t <= 5; t++) begin
        for (int g = 0; g < 2; g++) begin
          div_cfg = 8'(d == 3 ? 4 : d);
          timeout = {16'd1, 16'(t)};
          do_reset();
          tag = "R9"; fault = 2'b11; cyc(3);
          fault = 2'b10; tag = "R3";
          cyc(t * (int'(div_cfg) + 1) / 2 + 1);
          if (g == 1) begin tag = "R4"; fault[0] = 1'b1; cyc(1); fault[0] = 1'b0; end
          tag = "R3";
          cyc((t + 2) * (int'(div_cfg) + 1) + 2);
        end
      end
    end

    // R5 / R6: timer off, manual path
    div_cfg = 8'd0;
    timeout = {16'd0, 16'd0};
    do_reset();
    tag = "R5"; cyc(20);
    man = 2'b01; cyc(1); man = '0; cyc(30);
    tag = "R4"; fault = 2'b01; cyc(1); fault = '0; cyc(3);
    tag = "R6"; fault = 2'b10; man = 2'b10; cyc(1); man = '0; fault = '0; cyc(5);
    tag = "R5"; man = 2'b10; cyc(1); man = '0; cyc(5);

    // R6: manual ignored while timer active
    timeout = {16'd0, 16'd50};
    do_reset();
    tag = "R6"; man = 2'b01; cyc(3); man = '0; cyc(20);

    // R7 / R8: overrides over invalid and valid states
    for (int c = 0; c < 4; c++) begin
      fv = {1'b0, c[0]}; fi = {1'b0, c[1]};
      tag = c[1] ? "R8" : "R7";
      cyc(3);
      fv = '0; fi = '0;
    end
    timeout = {16'd0, 16'd2};
    cyc(10);
    for (int c = 0; c < 4; c++) begin
      fv = {c[0], c[0]}; fi = {c[1], c[1]};
      tag = c[1] ? "R8" : "R7";
      cyc(3);
    end
    fv = '0; fi = '0;

    // R10: full-scale timeout
    div_cfg = 8'd0;
    timeout = {16'hFFFF, 16'd1};
    do_reset();
    tag = "R10";
    cyc(65540);

    finish_run();
  end
endmodule